// File: doc/BRIEF.md
# Programmable Flag I/O Controller

This block manages sixteen general-purpose flag pins for a processor core. Software can make each pin an input or an output. It drives output values and arms interrupts through separate set and clear write addresses, so one pin can change without a read-modify-write. For each pin, software also picks the interrupt polarity and whether the pin is level triggered or edge triggered. An edge-triggered pin responds either to the rising edge only or to both edges.

Each external input passes through a two-stage synchronizer. The synchronized value can be read back. For an input pin, the interrupt source is this synchronized value. For an output pin, the source is the value software drives, which gives a software interrupt. The polarity bit is applied first. After that, an edge-triggered pin records its event in a sticky pending bit, and a level-triggered pin presents its current condition. The enabled sources are ORed into one interrupt request.

The register port is a single-cycle write strobe with a combinational read. Address map (4-bit address):

| Address | Write effect | Read value |
|---|---|---|
| 0 | Direction (1 = output) | Direction |
| 1 | Set the output bits written as 1 | Data view |
| 2 | Clear the output bits written as 1 | Data view |
| 3 | Enable the interrupts written as 1 | Mask |
| 4 | Disable the interrupts written as 1 | Mask |
| 5 | Polarity (1 = active low) | Polarity |
| 6 | Sense (1 = edge, 0 = level) | Sense |
| 7 | Both-edge select (1 = both edges) | Both-edge select |
| 8 | Clear the pending bits written as 1 | Pending |

The data view shows the output register on output pins and the synchronized input on input pins. Any other address reads 0.

Top module: `flag_gpio`

## Requirements
- R1: After reset every register reads 0, `pin_oe` is 0 and `irq` is 0.
- R2: `pin_oe` equals the direction register (address 0), and `pin_out` equals the output register.
- R3: A write to address 1 sets the output bits that are 1 in the write data and leaves the other bits unchanged.
- R4: A write to address 2 clears the output bits that are 1 in the write data and leaves the other bits unchanged.
- R5: A write to address 3 sets mask bits and a write to address 4 clears mask bits; in both cases only the bits written as 1 change. The mask reads back at address 3.
- R6: For an input pin, the data view at address 1 shows a change on `pin_in` at the second rising clock edge after the change. For an output pin, the data view shows the output register.
- R7: A level-triggered pin with its mask bit set drives `irq` while its condition is true. The condition is the source value when polarity is 0 and the inverted source value when polarity is 1.
- R8: On an edge-triggered pin, a rising condition sets the pin's pending bit (address 8). The bit stays set after the condition falls, and drives `irq` when the pin's mask bit is set.
- R9: A falling condition sets the pending bit only when the pin's both-edge bit (address 7) is 1.
- R10: Writing 1 to a pending bit at address 8 clears it. Bits written as 0 are unchanged, and with no such write a pending bit never clears.
- R11: On an output pin, the interrupt source is the output register, so setting the output raises a software interrupt without any activity on `pin_in`.
- R12: A masked pin still records its pending bit but does not drive `irq`. Setting its mask bit later raises `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from `bus_addr` |
| pin_in | input | 16 | External pin levels, asynchronous |
| pin_out | output | 16 | Output value for each pin |
| pin_oe | output | 16 | Output enable for each pin |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest cases to reach are the edge cases where the condition falls. The pending bit must be cleared first, after the rising edge that set it. The pin is then released and the result is observed: the pending bit stays 0 in rising-only mode and is set again in both-edge mode. The bench builds these sequences from register writes and pin changes, each placed at a negative clock edge. It waits the three clock edges of synchronizer and edge-detect latency before reading the pending register. The software-interrupt path is reached by switching a pin to output while an opposing level is held on `pin_in`, which shows that the external level is ignored.

// File: rtl/flag_gpio_pkg.sv
package flag_gpio_pkg;
    localparam int REG_AW = 4;

    typedef enum logic [REG_AW-1:0] {
        SEL_DIR      = 4'd0,
        SEL_DATA_SET = 4'd1,
        SEL_DATA_CLR = 4'd2,
        SEL_MASK_SET = 4'd3,
        SEL_MASK_CLR = 4'd4,
        SEL_POL      = 4'd5,
        SEL_SENSE    = 4'd6,
        SEL_BOTH     = 4'd7,
        SEL_PEND     = 4'd8
    } reg_sel_e;
endpackage

// File: rtl/flag_sync.sv
module flag_sync #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;
    logic             up_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
            up_q     <= 1'b0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
            up_q     <= 1'b1;
        end
    end

    assign sync_out = stage2_q;

    // R6: each synchronizer stage takes one clock
    a_r6_first_stage: assert property (@(posedge clk) disable iff (!rst_n)
        up_q |-> (stage1_q == $past(async_in)));
    a_r6_second_stage: assert property (@(posedge clk) disable iff (!rst_n)
        up_q |-> (sync_out == $past(stage1_q)));
endmodule

// File: rtl/flag_regs.sv
module flag_regs
    import flag_gpio_pkg::*;
#(
    parameter int NPIN = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [REG_AW-1:0] addr,
    input  logic [NPIN-1:0]   wdata,
    input  logic [NPIN-1:0]   sync_in,
    input  logic [NPIN-1:0]   pend,
    output logic [NPIN-1:0]   rdata,
    output logic [NPIN-1:0]   dir_q,
    output logic [NPIN-1:0]   out_q,
    output logic [NPIN-1:0]   mask_q,
    output logic [NPIN-1:0]   pol_q,
    output logic [NPIN-1:0]   sense_q,
    output logic [NPIN-1:0]   both_q,
    output logic [NPIN-1:0]   pend_clr
);
    logic [NPIN-1:0] data_view;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q   <= '0;
            out_q   <= '0;
            mask_q  <= '0;
            pol_q   <= '0;
            sense_q <= '0;
            both_q  <= '0;
        end else if (we) begin
            unique case (reg_sel_e'(addr))
                SEL_DIR:      dir_q   <= wdata;
                SEL_DATA_SET: out_q   <= out_q | wdata;
                SEL_DATA_CLR: out_q   <= out_q & ~wdata;
                SEL_MASK_SET: mask_q  <= mask_q | wdata;
                SEL_MASK_CLR: mask_q  <= mask_q & ~wdata;
                SEL_POL:      pol_q   <= wdata;
                SEL_SENSE:    sense_q <= wdata;
                SEL_BOTH:     both_q  <= wdata;
                default:      ;
            endcase
        end
    end

    assign pend_clr  = (we && addr == SEL_PEND) ? wdata : '0;
    assign data_view = (dir_q & out_q) | (~dir_q & sync_in);

    always_comb begin
        unique case (reg_sel_e'(addr))
            SEL_DIR:      rdata = dir_q;
            SEL_DATA_SET,
            SEL_DATA_CLR: rdata = data_view;
            SEL_MASK_SET,
            SEL_MASK_CLR: rdata = mask_q;
            SEL_POL:      rdata = pol_q;
            SEL_SENSE:    rdata = sense_q;
            SEL_BOTH:     rdata = both_q;
            SEL_PEND:     rdata = pend;
            default:      rdata = '0;
        endcase
    end

    a_r3_set_port: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == SEL_DATA_SET) |=> (out_q == ($past(out_q) | $past(wdata))));
    a_r4_clr_port: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == SEL_DATA_CLR) |=> ((out_q & $past(wdata)) == '0));
    a_r5_mask_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == SEL_MASK_CLR) |=> ((mask_q & $past(wdata)) == '0));
endmodule

// File: rtl/flag_irq.sv
module flag_irq #(
    parameter int NPIN = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] src,
    input  logic [NPIN-1:0] pol,
    input  logic [NPIN-1:0] sense,
    input  logic [NPIN-1:0] both,
    input  logic [NPIN-1:0] mask,
    input  logic [NPIN-1:0] pend_clr,
    output logic [NPIN-1:0] pend_q,
    output logic            irq
);
    logic [NPIN-1:0] cond;
    logic [NPIN-1:0] prev_q;
    logic [NPIN-1:0] evt;
    logic [NPIN-1:0] active;

    assign cond = src ^ pol;
    assign evt  = (cond & ~prev_q) | (both & ~cond & prev_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            pend_q <= '0;
        end else begin
            prev_q <= cond;
            pend_q <= (pend_q & ~pend_clr) | (evt & sense);
        end
    end

    assign active = (sense & pend_q) | (~sense & cond);
    assign irq    = |(active & mask);

    // R8: a pending bit only appears after an edge event on an edge pin
    a_r8_pend_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q & ~$past(pend_q) & ~$past(evt & sense)) == '0));
    // R10: without a clear write, no pending bit drops
    a_r10_pend_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_clr == '0) |=> (($past(pend_q) & ~pend_q) == '0));
endmodule

// File: rtl/flag_gpio.sv
module flag_gpio
    import flag_gpio_pkg::*;
#(
    parameter int NPIN = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [NPIN-1:0]   bus_wdata,
    output logic [NPIN-1:0]   bus_rdata,
    input  logic [NPIN-1:0]   pin_in,
    output logic [NPIN-1:0]   pin_out,
    output logic [NPIN-1:0]   pin_oe,
    output logic              irq
);
    logic [NPIN-1:0] sync_in;
    logic [NPIN-1:0] dir_q, out_q, mask_q, pol_q, sense_q, both_q;
    logic [NPIN-1:0] pend_q, pend_clr, src;

    flag_sync #(.WIDTH(NPIN)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (sync_in)
    );

    flag_regs #(.NPIN(NPIN)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (bus_we),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .sync_in  (sync_in),
        .pend     (pend_q),
        .rdata    (bus_rdata),
        .dir_q    (dir_q),
        .out_q    (out_q),
        .mask_q   (mask_q),
        .pol_q    (pol_q),
        .sense_q  (sense_q),
        .both_q   (both_q),
        .pend_clr (pend_clr)
    );

    assign src = (dir_q & out_q) | (~dir_q & sync_in);

    flag_irq #(.NPIN(NPIN)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      (src),
        .pol      (pol_q),
        .sense    (sense_q),
        .both     (both_q),
        .mask     (mask_q),
        .pend_clr (pend_clr),
        .pend_q   (pend_q),
        .irq      (irq)
    );

    assign pin_out = out_q;
    assign pin_oe  = dir_q;
endmodule

// File: tb/test_flag_gpio.sv
module test_flag_gpio;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;
    // {write address, write data, read address, expected read}
    localparam logic [39:0] VEC [0:NVEC-1] = '{
        {4'd0, 16'h00FF, 4'd0, 16'h00FF},
        {4'd1, 16'h0F0F, 4'd1, 16'h000F},
        {4'd2, 16'h0003, 4'd1, 16'h000C},
        {4'd3, 16'hA005, 4'd3, 16'hA005},
        {4'd4, 16'h8001, 4'd3, 16'h2004},
        {4'd5, 16'h1234, 4'd5, 16'h1234},
        {4'd6, 16'hFFFF, 4'd6, 16'hFFFF},
        {4'd7, 16'h00F0, 4'd7, 16'h00F0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out, pin_oe;
    logic        irq;
    int          n_checks = 0;
    int          n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flag_gpio i_flag_gpio (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_neg(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_we = 1'b0;
        wait_neg(3);
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] r;
        do_reset();
        // R1 reset state
        check("R1 oe", pin_oe, 16'h0);
        check("R1 irq", {15'h0, irq}, 16'h0);
        rd(4'd0, r); check("R1 dir", r, 16'h0);
        rd(4'd3, r); check("R1 mask", r, 16'h0);
        rd(4'd8, r); check("R1 pend", r, 16'h0);

        // register vectors: R2 R3 R4 R5
        for (int i = 0; i < NVEC; i++) begin
            wr(VEC[i][39:36], VEC[i][35:20]);
            rd(VEC[i][19:16], r);
            check("R3/R4/R5 vector", r, VEC[i][15:0]);
        end
        check("R2 oe", pin_oe, 16'h00FF);
        check("R2 out", pin_out, 16'h0F0C);

        // R6 synchronizer latency
        do_reset();
        pin_in = 16'h0A50;
        wait_neg(1);
        rd(4'd1, r); check("R6 one edge", r, 16'h0000);
        wait_neg(1);
        rd(4'd1, r); check("R6 two edges", r, 16'h0A50);

        // R7 level and polarity
        do_reset();
        pin_in = 16'h0;
        wr(4'd3, 16'h0001);
        pin_in = 16'h0001;
        wait_neg(1);
        check("R7 not yet", {15'h0, irq}, 16'h0);
        wait_neg(1);
        check("R7 level high", {15'h0, irq}, 16'h1);
        wr(4'd5, 16'h0001);
        check("R7 inverted off", {15'h0, irq}, 16'h0);
        pin_in = 16'h0;
        wait_neg(2);
        check("R7 active low", {15'h0, irq}, 16'h1);

        // R8 rising edge, sticky
        do_reset();
        pin_in = 16'h0;
        wr(4'd3, 16'h0002);
        wr(4'd6, 16'h0002);
        pin_in = 16'h0002;
        wait_neg(1);
        pin_in = 16'h0;
        wait_neg(4);
        check("R8 irq", {15'h0, irq}, 16'h1);
        rd(4'd8, r); check("R8 pend sticky", r, 16'h0002);
        wr(4'd8, 16'h0002);
        rd(4'd8, r); check("R10 cleared", r, 16'h0);
        check("R10 irq low", {15'h0, irq}, 16'h0);

        // R9 rising-only ignores the fall
        pin_in = 16'h0002;
        wait_neg(3);
        rd(4'd8, r); check("R8 rise again", r, 16'h0002);
        wr(4'd8, 16'h0002);
        pin_in = 16'h0;
        wait_neg(3);
        rd(4'd8, r); check("R9 fall ignored", r, 16'h0);
        // R9 both edges
        wr(4'd7, 16'h0002);
        pin_in = 16'h0002;
        wait_neg(3);
        wr(4'd8, 16'h0002);
        pin_in = 16'h0;
        wait_neg(3);
        rd(4'd8, r); check("R9 fall counted", r, 16'h0002);
        // R10 zeros do not clear
        wr(4'd8, 16'hFFFD);
        rd(4'd8, r); check("R10 zeros ignored", r, 16'h0002);
        wr(4'd8, 16'h0002);
        rd(4'd8, r); check("R10 one clears", r, 16'h0);

        // R12 masked pending
        wr(4'd4, 16'h0002);
        pin_in = 16'h0002;
        wait_neg(3);
        rd(4'd8, r); check("R12 pend recorded", r, 16'h0002);
        check("R12 masked", {15'h0, irq}, 16'h0);
        wr(4'd3, 16'h0002);
        check("R12 unmasked", {15'h0, irq}, 16'h1);

        // R11 software interrupt from an output pin
        do_reset();
        pin_in = 16'h0010;
        wr(4'd0, 16'h0010);
        wr(4'd6, 16'h0010);
        wr(4'd3, 16'h0010);
        wait_neg(3);
        rd(4'd8, r); check("R11 pin level ignored", r, 16'h0);
        pin_in = 16'h0;
        wait_neg(3);
        wr(4'd1, 16'h0010);
        wait_neg(1);
        rd(4'd8, r); check("R11 pend", r, 16'h0010);
        check("R11 irq", {15'h0, irq}, 16'h1);
        check("R2 out drive", pin_out, 16'h0010);
        rd(4'd1, r); check("R6 output view", r, 16'h0010);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule